// File: doc/BRIEF.md
# RGMII Reference Clock Generator

This block derives the RGMII reference clock from one fast base clock (250 MHz by default). It divides that clock by toggling a registered output after a programmable number of base cycles. Each toggle ends one half-period. Three link rates are supported: 1000 Mbps gives 125 MHz, 100 Mbps gives 25 MHz, and 10 Mbps gives 2.5 MHz. The base clock runs at 250 MHz, so these rates need 1, 5 and 50 base cycles per half-period.

The starting rate comes from a strap input and is loaded while reset is held. The strap selects either 1000 or 100 Mbps. After reset, a one-cycle write strobe with a 2-bit code can move the clock to any of the three rates. The generator never applies a new rate in the middle of a level. It waits until the current half-period ends. If the new half-period is longer, the current level is stretched to that length. If the new half-period is shorter, the level still runs to its full old length. No runt high or low pulse can reach the link partner. A one-cycle flag marks the base cycle in which the new divider takes effect. The rate currently in force is always visible on an output.

Top module: `rgmii_clkgen`

## Requirements
- R1: While reset is held (rst_n low for at least one clock edge), the clock output is low, the applied flag is low, and the speed output equals the strap value: code 2'b10 (1000 Mbps) when strap_gig is 1, and code 2'b01 (100 Mbps) when strap_gig is 0.
- R2: When no speed change is in progress, every high and low level lasts exactly the half-period of the speed in force, counted in base cycles: 1 for code 2'b10, 5 for code 2'b01, and 50 for code 2'b00.
- R3: A write strobe carrying code 2'b00 (10 Mbps), 2'b01 (100 Mbps) or 2'b10 (1000 Mbps) selects that speed. The speed output shows the new code once the change has taken effect.
- R4: A write carrying code 2'b11 is ignored. The speed output, the clock half-period and the applied flag are all unaffected.
- R5: A new speed takes effect only when a half-period of the old speed completes. The level in progress at that point lasts the longer of the old and the new half-periods, then the new half-period applies.
- R6: The applied flag is high for exactly one base cycle for each change that takes effect. The speed output changes in that same cycle and at no other time.
- R7: Writing the code of the speed already in force causes no applied pulse and no change in clock timing.
- R8: When several legal writes land within one half-period, only the last one takes effect at the next boundary. This produces a single applied pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_base | input | 1 | Base clock (250 MHz for the default divider settings) |
| rst_n | input | 1 | Synchronous reset, active low |
| strap_gig | input | 1 | Power-up speed select: 1 = 1000 Mbps, 0 = 100 Mbps |
| spd_wr | input | 1 | One-cycle strobe that writes a new speed code |
| spd_code | input | 2 | Speed code for the write: 00 = 10, 01 = 100, 10 = 1000 Mbps, 11 ignored |
| rgmii_clk_o | output | 1 | Generated reference clock, driven from a flop |
| spd_now_o | output | 2 | Speed code currently applied by the divider |
| spd_applied_o | output | 1 | One-cycle pulse when a new divider setting takes effect |

## Verification
The bench moves between every ordered pair of speeds. It places each write at several offsets after a clock edge, so that a change lands early, midway or near the end of a level. Every level is timed against the half-periods, which the bench derives from the output frequencies. A design that switched the divider in mid-level would produce a level shorter than both half-periods. A design that stretched wrongly would produce one longer than the larger half-period. The bench also covers the reserved code, a rewrite of the current speed and two writes inside one 100 Mbps level. A design that acted on any of these would show a stray applied pulse, a wrong speed code or a mistimed level.

// File: rtl/rgmii_clk_pkg.sv
package rgmii_clk_pkg;

  typedef enum logic [1:0] {
    SPD_10   = 2'b00,
    SPD_100  = 2'b01,
    SPD_1000 = 2'b10,
    SPD_RSVD = 2'b11
  } speed_e;

  // Base cycles per half-period for a given speed.
  function automatic int unsigned half_len(speed_e s, int unsigned h_gig,
                                           int unsigned h_fast, int unsigned h_slow);
    case (s)
      SPD_1000: return h_gig;
      SPD_100:  return h_fast;
      default:  return h_slow;
    endcase
  endfunction

  function automatic logic code_legal(logic [1:0] c);
    return c != 2'b11;
  endfunction

endpackage

// File: rtl/rgmii_spd_select.sv
module rgmii_spd_select
  import rgmii_clk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_gig,
  input  logic       wr_en,
  input  logic [1:0] wr_code,
  output speed_e     strap_spd,
  output speed_e     req_spd,
  output logic       wr_taken
);

  assign strap_spd = strap_gig ? SPD_1000 : SPD_100;
  assign wr_taken  = wr_en && code_legal(wr_code);

  always_ff @(posedge clk) begin
    if (!rst_n)        req_spd <= strap_spd;
    else if (wr_taken) req_spd <= speed_e'(wr_code);
  end

  AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_code == 2'b11) |=> $stable(req_spd)); // R4

  AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_code != 2'b11) |=> (req_spd == speed_e'($past(wr_code)))); // R3

endmodule

// File: rtl/rgmii_clk_divider.sv
module rgmii_clk_divider
  import rgmii_clk_pkg::*;
#(
  parameter int unsigned HALF_GIG  = 1,
  parameter int unsigned HALF_FAST = 5,
  parameter int unsigned HALF_SLOW = 50
) (
  input  logic   clk,
  input  logic   rst_n,
  input  speed_e init_spd,
  input  speed_e req_spd,
  output logic   clk_q,
  output speed_e act_spd,
  output logic   applied,
  output logic   phase_end,
  output logic   chg_pend
);

  localparam int unsigned CW = $clog2(HALF_SLOW + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_act;
  logic [CW-1:0] lim_req;
  logic          stretch;

  assign lim_act   = CW'(half_len(act_spd, HALF_GIG, HALF_FAST, HALF_SLOW));
  assign lim_req   = CW'(half_len(req_spd, HALF_GIG, HALF_FAST, HALF_SLOW));
  assign phase_end = (cnt_q == lim_act - CW'(1));
  assign chg_pend  = (req_spd != act_spd);
  assign stretch   = chg_pend && (lim_req > lim_act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      clk_q   <= 1'b0;
      act_spd <= init_spd;
      applied <= 1'b0;
    end else begin
      applied <= 1'b0;
      if (phase_end) begin
        if (chg_pend) begin
          act_spd <= req_spd;
          applied <= 1'b1;
        end
        if (stretch) begin
          cnt_q <= cnt_q + CW'(1);
        end else begin
          cnt_q <= '0;
          clk_q <= ~clk_q;
        end
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  AST_APPLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    applied |-> $past(phase_end)); // R5

  AST_APPLIED_CHG: assert property (@(posedge clk) disable iff (!rst_n)
    applied |-> (act_spd != $past(act_spd))); // R6

  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !applied |-> $stable(act_spd)); // R6

endmodule

// File: rtl/rgmii_clkgen.sv
module rgmii_clkgen
  import rgmii_clk_pkg::*;
#(
  parameter int unsigned HALF_GIG  = 1,
  parameter int unsigned HALF_FAST = 5,
  parameter int unsigned HALF_SLOW = 50
) (
  input  logic       clk_base,
  input  logic       rst_n,
  input  logic       strap_gig,
  input  logic       spd_wr,
  input  logic [1:0] spd_code,
  output logic       rgmii_clk_o,
  output logic [1:0] spd_now_o,
  output logic       spd_applied_o
);

  speed_e strap_spd;
  speed_e req_spd;
  speed_e act_spd;
  logic   wr_taken;
  logic   phase_end;
  logic   chg_pend;

  rgmii_spd_select u_sel (
    .clk       (clk_base),
    .rst_n     (rst_n),
    .strap_gig (strap_gig),
    .wr_en     (spd_wr),
    .wr_code   (spd_code),
    .strap_spd (strap_spd),
    .req_spd   (req_spd),
    .wr_taken  (wr_taken)
  );

  rgmii_clk_divider #(
    .HALF_GIG  (HALF_GIG),
    .HALF_FAST (HALF_FAST),
    .HALF_SLOW (HALF_SLOW)
  ) u_div (
    .clk       (clk_base),
    .rst_n     (rst_n),
    .init_spd  (strap_spd),
    .req_spd   (req_spd),
    .clk_q     (rgmii_clk_o),
    .act_spd   (act_spd),
    .applied   (spd_applied_o),
    .phase_end (phase_end),
    .chg_pend  (chg_pend)
  );

  assign spd_now_o = act_spd;

  // Level-length observer: times each output level independently of the divider counter.
  logic        prev_clk;
  logic        lvl_chg;
  int unsigned plen;
  speed_e      pspd;
  logic        chg_seen;
  logic        tog;

  assign tog = (rgmii_clk_o != prev_clk);

  always_ff @(posedge clk_base) begin
    if (!rst_n) begin
      prev_clk <= 1'b0;
      plen     <= 0;
      pspd     <= act_spd;
      chg_seen <= 1'b0;
    end else begin
      prev_clk <= rgmii_clk_o;
      if (tog) begin
        plen     <= 1;
        pspd     <= act_spd;
        chg_seen <= 1'b0;
      end else begin
        plen <= plen + 1;
        if (spd_applied_o) chg_seen <= 1'b1;
      end
    end
  end

  assign lvl_chg = chg_seen || spd_applied_o;

  AST_PHASE_MIN: assert property (@(posedge clk_base) disable iff (!rst_n)
    tog |-> (plen >= half_len(pspd, HALF_GIG, HALF_FAST, HALF_SLOW))); // R5

  AST_STEADY_HALF: assert property (@(posedge clk_base) disable iff (!rst_n)
    (tog && !lvl_chg) |-> (plen == half_len(pspd, HALF_GIG, HALF_FAST, HALF_SLOW))); // R2

endmodule

// File: tb/sim_rgmii_clkgen.sv
module sim_rgmii_clkgen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap = 1'b0;
  logic       wr = 1'b0;
  logic [1:0] code = 2'b00;
  logic       clk_o;
  logic [1:0] now;
  logic       app;

  always #4 clk = ~clk;

  rgmii_clkgen u0 (
    .clk_base      (clk),
    .rst_n         (rst_n),
    .strap_gig     (strap),
    .spd_wr        (wr),
    .spd_code      (code),
    .rgmii_clk_o   (clk_o),
    .spd_now_o     (now),
    .spd_applied_o (app)
  );

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  localparam int SETTLE = 240;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Half-period in 250 MHz base cycles from the output frequency in kHz.
  function automatic int halfof(int c);
    int fk;
    fk = (c == 2) ? 125000 : ((c == 1) ? 25000 : 2500);
    return 250000 / (2 * fk);
  endfunction

  // Level monitor.
  bit armed = 0;
  bit seen_first, pend, last_app;
  logic last;
  int run;
  int exp_old, exp_new;
  int pulses;

  always @(negedge clk) begin
    if (!armed) begin
      seen_first = 0;
      pend = 0;
      last_app = 0;
      last = clk_o;
      run = 0;
    end else begin
      if (app) begin
        pulses++;
        if (last_app) chk(0, "R6", "applied pulse wider than one cycle", 2, 1);
        pend = 1;
      end
      run++;
      if (clk_o != last) begin
        if (seen_first) begin
          if (pend) begin
            int e;
            e = (halfof(exp_old) > halfof(exp_new)) ? halfof(exp_old) : halfof(exp_new);
            chk(run == e, "R5", "transition level length", run, e);
            pend = 0;
            exp_old = exp_new;
          end else begin
            chk(run == halfof(exp_old), "R2", "steady level length", run, halfof(exp_old));
          end
        end
        seen_first = 1;
        run = 0;
      end
      last = clk_o;
      last_app = app;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      chk(0, "R2", "watchdog expired", cycles, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic do_reset(bit s);
    armed = 0;
    rst_n = 0;
    strap = s;
    wr = 0;
    repeat (4) @(negedge clk);
    chk(clk_o == 1'b0, "R1", "clock low in reset", int'(clk_o), 0);
    chk(app == 1'b0, "R1", "applied low in reset", int'(app), 0);
    chk(int'(now) == (s ? 2 : 1), "R1", "strap speed", int'(now), s ? 2 : 1);
    exp_old = s ? 2 : 1;
    exp_new = exp_old;
    rst_n = 1;
    armed = 1;
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic sync_toggle();
    logic p;
    @(negedge clk);
    p = clk_o;
    while (clk_o == p) @(negedge clk);
  endtask

  task automatic write_spd(int c, int d);
    sync_toggle();
    repeat (d) @(negedge clk);
    pulses = 0;
    wr = 1;
    code = 2'(c);
    if (c != 3) exp_new = c;
    @(negedge clk);
    wr = 0;
    repeat (SETTLE) @(negedge clk);
  endtask

  initial begin
    int offs[4];
    offs = '{0, 1, 3, 6};

    do_reset(1'b0);
    chk(int'(now) == 1, "R1", "strap 0 speed after release", int'(now), 1);

    do_reset(1'b1);
    chk(int'(now) == 2, "R1", "strap 1 speed after release", int'(now), 2);

    // Sweep every ordered speed pair with several write offsets (R3, R5, R6).
    for (int f = 0; f < 3; f++) begin
      for (int t = 0; t < 3; t++) begin
        for (int k = 0; k < 4; k++) begin
          write_spd(f, 0);
          chk(int'(now) == f, "R3", "speed after write", int'(now), f);
          write_spd(t, offs[k]);
          chk(int'(now) == t, "R3", "speed after write", int'(now), t);
          chk(pulses == ((f != t) ? 1 : 0), (f == t) ? "R7" : "R6",
              "applied pulse count", pulses, (f != t) ? 1 : 0);
        end
      end
    end

    // R4: reserved code ignored at 100 Mbps.
    write_spd(1, 0);
    write_spd(3, 2);
    chk(int'(now) == 1, "R4", "speed after reserved write", int'(now), 1);
    chk(pulses == 0, "R4", "pulses after reserved write", pulses, 0);

    // R7: rewrite of the current speed at 10 Mbps.
    write_spd(0, 0);
    write_spd(0, 17);
    chk(int'(now) == 0, "R7", "speed after rewrite", int'(now), 0);
    chk(pulses == 0, "R7", "pulses after rewrite", pulses, 0);

    // R8: two writes inside one 100 Mbps level; the last one wins.
    write_spd(1, 0);
    sync_toggle();
    pulses = 0;
    wr = 1;
    code = 2'b00;
    @(negedge clk);
    code = 2'b10;
    exp_new = 2;
    @(negedge clk);
    wr = 0;
    repeat (SETTLE) @(negedge clk);
    chk(int'(now) == 2, "R8", "speed after double write", int'(now), 2);
    chk(pulses == 1, "R8", "pulses after double write", pulses, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule